// File: doc/BRIEF.md
# Phase History Table with Nearest-Phase Lookup

This block keeps a small record of execution phases that have already been tuned. Each record pairs a phase identifier and a vector of measured characteristics (for example miss counts or other per-interval statistics, each quantised to a fixed-width field) with the cache configuration that tuning found best for that phase. A configuration is an opaque code to this block.

When a new phase begins, its identifier and characteristic vector are presented as a lookup. The block scans every stored record, one per clock, newest first. If a record with the same identifier exists, the lookup reports a hit and returns that record's configuration, so the tuner can skip tuning. Otherwise, it returns the configuration of the record whose characteristics lie nearest the new phase, which the tuner uses as its starting point. Once tuning of a new phase is finished, the tuner stores the result through the store port. That port updates an existing record in place or allocates a new one, and the oldest allocation is overwritten once the table is full.

Top module: `phase_hist_table`

## Requirements
- R1: After reset, busy, done, hit and found are 0, the configuration and distance outputs are 0, and the table holds no valid record.
- R2: A lookup is accepted on a rising edge where lookup_valid is 1 and busy is 0. Busy is then 1 until the result is delivered, and lookup requests made while busy is 1 are ignored and produce no extra result.
- R3: Done is a one-cycle pulse that rises exactly DEPTH clock edges after the accepting edge.
- R4: If a valid record carries the lookup identifier, the result has hit=1 and found=1, and it returns that record's configuration and its distance to the lookup vector.
- R5: If no record carries the identifier but at least one record is valid, the result has hit=0 and found=1, and it returns the configuration and distance of the valid record at minimum distance.
- R6: Distance is the sum over NFIELD fields of the absolute difference of unsigned fields, where field k occupies bits [k*FIELD_W +: FIELD_W] of a vector.
- R7: When several records share the minimum distance, the one allocated most recently is chosen.
- R8: If no record is valid, the result has hit=0, found=0, configuration 0 and distance 0.
- R9: A store whose identifier is not in the table allocates a record. When all DEPTH records are valid, it overwrites the record allocated longest ago.
- R10: A store whose identifier is already in the table replaces that record's vector and configuration but keeps its allocation age.
- R11: A store made on the same edge that accepts a lookup is visible to that lookup.
- R12: The result outputs (hit, found, configuration, distance) keep their values from one done pulse to the next, including across stores.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lookup_valid_i | input | 1 | Lookup request |
| lookup_id_i | input | ID_W | Identifier of the phase being looked up |
| lookup_vec_i | input | NFIELD*FIELD_W | Characteristic vector of the phase being looked up |
| store_en_i | input | 1 | Store request |
| store_id_i | input | ID_W | Identifier of the phase being stored |
| store_vec_i | input | NFIELD*FIELD_W | Characteristic vector being stored |
| store_cfg_i | input | CFG_W | Best configuration being stored |
| busy_o | output | 1 | A lookup scan is in progress |
| done_o | output | 1 | One-cycle pulse: result is valid |
| hit_o | output | 1 | The identifier was found in the table |
| found_o | output | 1 | At least one valid record was scanned |
| cfg_o | output | CFG_W | Returned configuration |
| dist_o | output | FIELD_W+$clog2(NFIELD+1) | Distance of the returned record |

## Verification
A store and a lookup can land on the same clock edge, and the store then decides what that lookup returns. The bench provokes this by raising both requests on one edge, rewriting the looked-up identifier's vector and configuration. It judges the result by requiring the new configuration and the distance to the new vector, which differ from the values the old record would give. A second collision, a lookup request held high during a scan, is judged by requiring the first query's result and no further done pulse.

// File: rtl/pht_pkg.sv
package pht_pkg;

  // Control state of the lookup scan
  typedef enum logic [0:0] {
    PH_IDLE = 1'b0,
    PH_SCAN = 1'b1
  } ph_state_e;

endpackage

// File: rtl/pht_dist.sv
// Sum of absolute differences over the characteristic fields
module pht_dist #(
  parameter int NFIELD  = 3,
  parameter int FIELD_W = 8,
  parameter int DIST_W  = 10
) (
  input  logic [NFIELD*FIELD_W-1:0] a_i,
  input  logic [NFIELD*FIELD_W-1:0] b_i,
  output logic [DIST_W-1:0]         dist_o
);

  logic [FIELD_W-1:0] absdiff [NFIELD];

  for (genvar k = 0; k < NFIELD; k++) begin : g_fld
    logic [FIELD_W-1:0] fa;
    logic [FIELD_W-1:0] fb;
    assign fa         = a_i[k*FIELD_W +: FIELD_W];
    assign fb         = b_i[k*FIELD_W +: FIELD_W];
    assign absdiff[k] = (fa >= fb) ? (fa - fb) : (fb - fa);
  end

  always_comb begin
    dist_o = '0;
    for (int k = 0; k < NFIELD; k++) begin
      dist_o = dist_o + DIST_W'(absdiff[k]);
    end
  end

endmodule

// File: rtl/pht_store.sv
// Record storage: identifier match on store, ring allocation, one read port
module pht_store #(
  parameter int DEPTH = 8,
  parameter int ID_W  = 8,
  parameter int VEC_W = 24,
  parameter int CFG_W = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [ID_W-1:0]  wr_id_i,
  input  logic [VEC_W-1:0] wr_vec_i,
  input  logic [CFG_W-1:0] wr_cfg_i,
  input  logic [PTR_W-1:0] rd_idx_i,
  output logic             rd_valid_o,
  output logic [ID_W-1:0]  rd_id_o,
  output logic [VEC_W-1:0] rd_vec_o,
  output logic [CFG_W-1:0] rd_cfg_o,
  output logic [PTR_W-1:0] head_nxt_o
);

  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);

  logic [DEPTH-1:0] valid_q, valid_d;
  logic [DEPTH-1:0] id_match;
  logic [DEPTH-1:0] slot_we;
  logic [PTR_W-1:0] head_q, head_d;
  logic [PTR_W-1:0] upd_idx, tgt_idx;
  logic             upd_found;

  logic [ID_W-1:0]  id_arr  [DEPTH];
  logic [VEC_W-1:0] vec_arr [DEPTH];
  logic [CFG_W-1:0] cfg_arr [DEPTH];

  // Per-record identifier compare and write enable
  for (genvar e = 0; e < DEPTH; e++) begin : g_cmp
    assign id_match[e] = valid_q[e] && (id_arr[e] == wr_id_i);
    assign slot_we[e]  = wr_en_i && (tgt_idx == PTR_W'(e));
  end

  // Lowest matching slot (identifiers are unique, so at most one matches)
  always_comb begin
    upd_found = 1'b0;
    upd_idx   = '0;
    for (int e = 0; e < DEPTH; e++) begin
      if (id_match[e] && !upd_found) begin
        upd_found = 1'b1;
        upd_idx   = PTR_W'(e);
      end
    end
  end

  // Target slot and allocation pointer
  always_comb begin
    tgt_idx = upd_found ? upd_idx : head_q;
    head_d  = head_q;
    if (wr_en_i && !upd_found) begin
      head_d = (head_q == LAST_SLOT) ? '0 : head_q + 1'b1;
    end
    valid_d = valid_q | slot_we;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q  <= '0;
      valid_q <= '0;
    end else if (wr_en_i) begin
      head_q  <= head_d;
      valid_q <= valid_d;
    end
  end

  // Record payload, no reset; each record has its own clock enable
  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    logic [ID_W-1:0]  id_q;
    logic [VEC_W-1:0] vec_q;
    logic [CFG_W-1:0] cfg_q;

    always_ff @(posedge clk_i) begin
      if (slot_we[e]) begin
        id_q  <= wr_id_i;
        vec_q <= wr_vec_i;
        cfg_q <= wr_cfg_i;
      end
    end

    assign id_arr[e]  = id_q;
    assign vec_arr[e] = vec_q;
    assign cfg_arr[e] = cfg_q;
  end

  assign rd_valid_o = valid_q[rd_idx_i];
  assign rd_id_o    = id_arr[rd_idx_i];
  assign rd_vec_o   = vec_arr[rd_idx_i];
  assign rd_cfg_o   = cfg_arr[rd_idx_i];
  assign head_nxt_o = head_d;

endmodule

// File: rtl/pht_search.sv
// Sequential scan, newest record first, one record per clock
module pht_search
  import pht_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int ID_W    = 8,
  parameter int NFIELD  = 3,
  parameter int FIELD_W = 8,
  parameter int CFG_W   = 8,
  localparam int VEC_W  = NFIELD * FIELD_W,
  localparam int DIST_W = FIELD_W + $clog2(NFIELD + 1),
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ID_W-1:0]   req_id_i,
  input  logic [VEC_W-1:0]  req_vec_i,
  input  logic [PTR_W-1:0]  head_i,
  output logic [PTR_W-1:0]  rd_idx_o,
  input  logic              rd_valid_i,
  input  logic [ID_W-1:0]   rd_id_i,
  input  logic [VEC_W-1:0]  rd_vec_i,
  input  logic [CFG_W-1:0]  rd_cfg_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              hit_o,
  output logic              found_o,
  output logic [CFG_W-1:0]  cfg_o,
  output logic [DIST_W-1:0] dist_o
);

  localparam logic [PTR_W-1:0] LAST_STEP = PTR_W'(DEPTH - 1);
  localparam logic [PTR_W:0]   DEPTH_X   = (PTR_W + 1)'(DEPTH);

  ph_state_e         state_q, state_d;
  logic [PTR_W-1:0]  step_q, step_d;
  logic              done_q, done_d;
  logic              res_hit_q, res_hit_d;
  logic              res_fnd_q, res_fnd_d;
  logic [CFG_W-1:0]  res_cfg_q, res_cfg_d;
  logic [DIST_W-1:0] res_dst_q, res_dst_d;

  logic [PTR_W-1:0]  base_q, base_d;
  logic [ID_W-1:0]   qid_q, qid_d;
  logic [VEC_W-1:0]  qvec_q, qvec_d;
  logic              hit_q, hit_d;
  logic [CFG_W-1:0]  hcfg_q, hcfg_d;
  logic [DIST_W-1:0] hdst_q, hdst_d;
  logic              bfnd_q, bfnd_d;
  logic [CFG_W-1:0]  bcfg_q, bcfg_d;
  logic [DIST_W-1:0] bdst_q, bdst_d;

  logic              accept;
  logic              scan;
  logic              acc_en;
  logic              last_step;
  logic [PTR_W:0]    slot_x;
  logic [DIST_W-1:0] cur_dist;

  assign accept    = (state_q == PH_IDLE) && req_i;
  assign scan      = (state_q == PH_SCAN);
  assign acc_en    = accept || scan;
  assign last_step = (step_q == LAST_STEP);

  // Slot visited this cycle: base-1-step, wrapped into the table
  always_comb begin
    slot_x = {1'b0, base_q} + (DEPTH_X - 1'b1) - {1'b0, step_q};
    if (slot_x >= DEPTH_X) begin
      slot_x = slot_x - DEPTH_X;
    end
  end
  assign rd_idx_o = slot_x[PTR_W-1:0];

  pht_dist #(
    .NFIELD (NFIELD),
    .FIELD_W(FIELD_W),
    .DIST_W (DIST_W)
  ) u_dist (
    .a_i   (qvec_q),
    .b_i   (rd_vec_i),
    .dist_o(cur_dist)
  );

  // Next-state and accumulator logic
  always_comb begin
    state_d   = state_q;
    step_d    = step_q;
    done_d    = 1'b0;
    res_hit_d = res_hit_q;
    res_fnd_d = res_fnd_q;
    res_cfg_d = res_cfg_q;
    res_dst_d = res_dst_q;
    base_d    = base_q;
    qid_d     = qid_q;
    qvec_d    = qvec_q;
    hit_d     = hit_q;
    hcfg_d    = hcfg_q;
    hdst_d    = hdst_q;
    bfnd_d    = bfnd_q;
    bcfg_d    = bcfg_q;
    bdst_d    = bdst_q;

    unique case (state_q)
      PH_IDLE: begin
        if (req_i) begin
          state_d = PH_SCAN;
          step_d  = '0;
          base_d  = head_i;
          qid_d   = req_id_i;
          qvec_d  = req_vec_i;
          hit_d   = 1'b0;
          hcfg_d  = '0;
          hdst_d  = '0;
          bfnd_d  = 1'b0;
          bcfg_d  = '0;
          bdst_d  = '0;
        end
      end
      PH_SCAN: begin
        if (rd_valid_i) begin
          if (rd_id_i == qid_q) begin
            hit_d  = 1'b1;
            hcfg_d = rd_cfg_i;
            hdst_d = cur_dist;
          end
          // strict compare: an earlier-visited (newer) record keeps a tie
          if (!bfnd_q || (cur_dist < bdst_q)) begin
            bfnd_d = 1'b1;
            bcfg_d = rd_cfg_i;
            bdst_d = cur_dist;
          end
        end
        if (last_step) begin
          state_d = PH_IDLE;
          done_d  = 1'b1;
          if (hit_d) begin
            res_hit_d = 1'b1;
            res_fnd_d = 1'b1;
            res_cfg_d = hcfg_d;
            res_dst_d = hdst_d;
          end else if (bfnd_d) begin
            res_hit_d = 1'b0;
            res_fnd_d = 1'b1;
            res_cfg_d = bcfg_d;
            res_dst_d = bdst_d;
          end else begin
            res_hit_d = 1'b0;
            res_fnd_d = 1'b0;
            res_cfg_d = '0;
            res_dst_d = '0;
          end
        end else begin
          step_d = step_q + 1'b1;
        end
      end
      default: state_d = PH_IDLE;
    endcase
  end

  // Control and result registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= PH_IDLE;
      step_q    <= '0;
      done_q    <= 1'b0;
      res_hit_q <= 1'b0;
      res_fnd_q <= 1'b0;
      res_cfg_q <= '0;
      res_dst_q <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (acc_en) begin
        step_q <= step_d;
      end
      if (done_d) begin
        res_hit_q <= res_hit_d;
        res_fnd_q <= res_fnd_d;
        res_cfg_q <= res_cfg_d;
        res_dst_q <= res_dst_d;
      end
    end
  end

  // Query and accumulator registers, no reset; loaded on accept
  always_ff @(posedge clk_i) begin
    if (acc_en) begin
      base_q <= base_d;
      qid_q  <= qid_d;
      qvec_q <= qvec_d;
      hit_q  <= hit_d;
      hcfg_q <= hcfg_d;
      hdst_q <= hdst_d;
      bfnd_q <= bfnd_d;
      bcfg_q <= bcfg_d;
      bdst_q <= bdst_d;
    end
  end

  assign busy_o  = scan;
  assign done_o  = done_q;
  assign hit_o   = res_hit_q;
  assign found_o = res_fnd_q;
  assign cfg_o   = res_cfg_q;
  assign dist_o  = res_dst_q;

endmodule

// File: rtl/phase_hist_table.sv
// Phase history table: exact-identifier hit or nearest stored phase
module phase_hist_table #(
  parameter int DEPTH   = 8,
  parameter int ID_W    = 8,
  parameter int NFIELD  = 3,
  parameter int FIELD_W = 8,
  parameter int CFG_W   = 8,
  localparam int VEC_W  = NFIELD * FIELD_W,
  localparam int DIST_W = FIELD_W + $clog2(NFIELD + 1),
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lookup_valid_i,
  input  logic [ID_W-1:0]   lookup_id_i,
  input  logic [VEC_W-1:0]  lookup_vec_i,
  input  logic              store_en_i,
  input  logic [ID_W-1:0]   store_id_i,
  input  logic [VEC_W-1:0]  store_vec_i,
  input  logic [CFG_W-1:0]  store_cfg_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              hit_o,
  output logic              found_o,
  output logic [CFG_W-1:0]  cfg_o,
  output logic [DIST_W-1:0] dist_o
);

  logic [PTR_W-1:0] rd_idx;
  logic [PTR_W-1:0] head_nxt;
  logic             rd_valid;
  logic [ID_W-1:0]  rd_id;
  logic [VEC_W-1:0] rd_vec;
  logic [CFG_W-1:0] rd_cfg;

  pht_store #(
    .DEPTH(DEPTH),
    .ID_W (ID_W),
    .VEC_W(VEC_W),
    .CFG_W(CFG_W)
  ) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (store_en_i),
    .wr_id_i   (store_id_i),
    .wr_vec_i  (store_vec_i),
    .wr_cfg_i  (store_cfg_i),
    .rd_idx_i  (rd_idx),
    .rd_valid_o(rd_valid),
    .rd_id_o   (rd_id),
    .rd_vec_o  (rd_vec),
    .rd_cfg_o  (rd_cfg),
    .head_nxt_o(head_nxt)
  );

  // head_nxt already includes a store on the accepting edge (R11)
  pht_search #(
    .DEPTH  (DEPTH),
    .ID_W   (ID_W),
    .NFIELD (NFIELD),
    .FIELD_W(FIELD_W),
    .CFG_W  (CFG_W)
  ) u_search (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (lookup_valid_i),
    .req_id_i  (lookup_id_i),
    .req_vec_i (lookup_vec_i),
    .head_i    (head_nxt),
    .rd_idx_o  (rd_idx),
    .rd_valid_i(rd_valid),
    .rd_id_i   (rd_id),
    .rd_vec_i  (rd_vec),
    .rd_cfg_i  (rd_cfg),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .hit_o     (hit_o),
    .found_o   (found_o),
    .cfg_o     (cfg_o),
    .dist_o    (dist_o)
  );

endmodule

// File: rtl/phase_hist_table_chk.sv
// Protocol checker for phase_hist_table
module phase_hist_table_chk #(
  parameter int DEPTH  = 8,
  parameter int CFG_W  = 8,
  parameter int DIST_W = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              lookup_valid_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              hit_o,
  input logic              found_o,
  input logic [CFG_W-1:0]  cfg_o,
  input logic [DIST_W-1:0] dist_o
);

  localparam int LAT_W = $clog2(DEPTH + 1) + 1;
  localparam logic [LAT_W-1:0] LAT_MAX = {LAT_W{1'b1}};

  // Clock edges since the last accepted lookup
  logic [LAT_W-1:0] lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q <= '0;
    end else if (lookup_valid_i && !busy_o) begin
      lat_q <= '0;
    end else if (busy_o && (lat_q != LAT_MAX)) begin
      lat_q <= lat_q + 1'b1;
    end
  end

  // R2: an accepted request makes the block busy
  a_r2_accept_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lookup_valid_i && !busy_o) |=> busy_o);

  // R2: no result is delivered while a scan is still running
  a_r2_no_done_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !done_o);

  // R3: done lasts one cycle
  a_r3_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R3: done arrives DEPTH edges after acceptance
  a_r3_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (lat_q == LAT_W'(DEPTH)));

  // R4: a hit is always a found result
  a_r4_hit_found: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && hit_o) |-> found_o);

  // R8: empty result carries zero configuration and distance
  a_r8_empty_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !found_o) |-> (!hit_o && (cfg_o == '0) && (dist_o == '0)));

  // R12: results change only with a done pulse
  a_r12_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(cfg_o) && $stable(dist_o) && $stable(hit_o) && $stable(found_o)));

endmodule

bind phase_hist_table phase_hist_table_chk #(
  .DEPTH (DEPTH),
  .CFG_W (CFG_W),
  .DIST_W(DIST_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .lookup_valid_i(lookup_valid_i),
  .busy_o        (busy_o),
  .done_o        (done_o),
  .hit_o         (hit_o),
  .found_o       (found_o),
  .cfg_o         (cfg_o),
  .dist_o        (dist_o)
);

// File: tb/phase_hist_table_tb.sv
`timescale 1ns/1ps
module phase_hist_table_tb;

  localparam int DEPTH  = 8;
  localparam int DIST_W = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        lookup_valid_i = 1'b0;
  logic [7:0]  lookup_id_i = '0;
  logic [23:0] lookup_vec_i = '0;
  logic        store_en_i = 1'b0;
  logic [7:0]  store_id_i = '0;
  logic [23:0] store_vec_i = '0;
  logic [7:0]  store_cfg_i = '0;
  logic        busy_o, done_o, hit_o, found_o;
  logic [7:0]  cfg_o;
  logic [DIST_W-1:0] dist_o;

  int checks = 0;
  int failures = 0;

  always #10 clk_i = ~clk_i;

  phase_hist_table u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .lookup_valid_i(lookup_valid_i), .lookup_id_i(lookup_id_i), .lookup_vec_i(lookup_vec_i),
    .store_en_i(store_en_i), .store_id_i(store_id_i), .store_vec_i(store_vec_i),
    .store_cfg_i(store_cfg_i),
    .busy_o(busy_o), .done_o(done_o), .hit_o(hit_o), .found_o(found_o),
    .cfg_o(cfg_o), .dist_o(dist_o)
  );

  // Vector: op(1: lookup, 0: store), id, vec {f2,f1,f0}, cfg, exp hit, exp found, exp cfg, exp dist
  localparam int NV = 8;
  localparam logic [60:0] TBL [NV] = '{
    {1'b1, 8'd1, 8'd30, 8'd20, 8'd10,    8'h00, 1'b0, 1'b0, 8'h00, 10'd0},   // R8 empty
    {1'b0, 8'd1, 8'd30, 8'd20, 8'd10,    8'h11, 1'b0, 1'b0, 8'h00, 10'd0},
    {1'b0, 8'd2, 8'd100, 8'd100, 8'd100, 8'h22, 1'b0, 1'b0, 8'h00, 10'd0},
    {1'b0, 8'd3, 8'd0, 8'd0, 8'd0,       8'h33, 1'b0, 1'b0, 8'h00, 10'd0},
    {1'b1, 8'd2, 8'd100, 8'd100, 8'd90,  8'h00, 1'b1, 1'b1, 8'h22, 10'd10},  // R4 hit
    {1'b1, 8'd9, 8'd30, 8'd18, 8'd12,    8'h00, 1'b0, 1'b1, 8'h11, 10'd4},   // R5 nearest
    {1'b1, 8'd9, 8'd60, 8'd60, 8'd60,    8'h00, 1'b0, 1'b1, 8'h22, 10'd120}, // R7 tie
    {1'b1, 8'd8, 8'd0, 8'd0, 8'd255,     8'h00, 1'b0, 1'b1, 8'h33, 10'd255}  // R6 fields
  };

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=%0d expected=%0d", req, got, exp);
    end
  endtask

  task automatic do_store(input logic [7:0] id, input logic [23:0] vec, input logic [7:0] cfg);
    @(negedge clk_i);
    store_en_i = 1'b1; store_id_i = id; store_vec_i = vec; store_cfg_i = cfg;
    @(negedge clk_i);
    store_en_i = 1'b0;
  endtask

  // Lookup with optional store on the accepting edge; returns edges to done
  task automatic do_lookup(input logic [7:0] id, input logic [23:0] vec, input logic with_st,
                           input logic [7:0] sid, input logic [23:0] svec, input logic [7:0] scfg,
                           output int lat);
    @(negedge clk_i);
    lookup_valid_i = 1'b1; lookup_id_i = id; lookup_vec_i = vec;
    store_en_i = with_st; store_id_i = sid; store_vec_i = svec; store_cfg_i = scfg;
    @(negedge clk_i);
    lookup_valid_i = 1'b0; store_en_i = 1'b0;
    lat = 0;
    while (!done_o && lat < 100) begin
      @(negedge clk_i);
      lat++;
    end
  endtask

  function automatic logic [23:0] v3(input int f0, input int f1, input int f2);
    return {8'(f2), 8'(f1), 8'(f0)};
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    int lat;
    int extra;
    // R1 reset state
    repeat (3) @(negedge clk_i);
    chk("R1 busy", busy_o, 0);
    chk("R1 done", done_o, 0);
    chk("R1 hit/found", {hit_o, found_o}, 0);
    chk("R1 cfg", cfg_o, 0);
    chk("R1 dist", dist_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // Vector walk (R3 latency checked on every lookup)
    for (int i = 0; i < NV; i++) begin
      logic [60:0] t;
      t = TBL[i];
      if (t[60]) begin
        do_lookup(t[59:52], t[51:28], 1'b0, '0, '0, '0, lat);
        chk($sformatf("R3 latency v%0d", i), lat, DEPTH);
        chk($sformatf("R4/R5 hit v%0d", i), hit_o, int'(t[19]));
        chk($sformatf("R5/R8 found v%0d", i), found_o, int'(t[18]));
        chk($sformatf("R5/R7 cfg v%0d", i), cfg_o, int'(t[17:10]));
        chk($sformatf("R6 dist v%0d", i), dist_o, int'(t[9:0]));
      end else begin
        do_store(t[59:52], t[51:28], t[27:20]);
      end
    end

    // R2: requests while busy are ignored
    @(negedge clk_i);
    lookup_valid_i = 1'b1; lookup_id_i = 8'd9; lookup_vec_i = v3(12, 18, 30);
    @(negedge clk_i);
    chk("R2 busy after accept", busy_o, 1);
    lookup_id_i = 8'd2; lookup_vec_i = v3(100, 100, 100);
    repeat (3) @(negedge clk_i);
    lookup_valid_i = 1'b0;
    lat = 4;
    while (!done_o && lat < 100) begin
      @(negedge clk_i);
      lat++;
    end
    chk("R2 first query result cfg", cfg_o, 8'h11);
    chk("R2 first query hit", hit_o, 0);
    chk("R2 first query dist", dist_o, 4);
    extra = 0;
    for (int c = 0; c < 12; c++) begin
      @(negedge clk_i);
      if (done_o) extra++;
    end
    chk("R2 no extra done", extra, 0);

    // R12: results hold across idle cycles and a store
    do_store(8'd3, v3(0, 0, 0), 8'h33);
    repeat (4) @(negedge clk_i);
    chk("R12 cfg held", cfg_o, 8'h11);
    chk("R12 dist held", dist_o, 4);

    // R10: in-place update
    do_store(8'd1, v3(60, 60, 60), 8'h44);
    do_lookup(8'd9, v3(60, 60, 60), 1'b0, '0, '0, '0, lat);
    chk("R10 updated cfg", cfg_o, 8'h44);
    chk("R10 updated dist", dist_o, 0);

    // R9: fill the table, then evict the oldest allocation (id 1)
    for (int k = 4; k <= 9; k++) begin
      do_store(8'(k), v3(250, 250, 250), 8'(8'h50 + k));
    end
    do_lookup(8'd1, v3(60, 60, 60), 1'b0, '0, '0, '0, lat);
    chk("R9 evicted id misses", hit_o, 0);
    chk("R9 found", found_o, 1);
    chk("R9/R10 nearest cfg", cfg_o, 8'h22);
    chk("R9 nearest dist", dist_o, 120);
    do_lookup(8'd9, v3(250, 250, 250), 1'b0, '0, '0, '0, lat);
    chk("R9 newest id hit", hit_o, 1);
    chk("R9 newest id cfg", cfg_o, 8'h59);

    // R11: store on the accepting edge is seen by that lookup
    do_lookup(8'd2, v3(60, 60, 60), 1'b1, 8'd2, v3(61, 60, 60), 8'h66, lat);
    chk("R11 latency", lat, DEPTH);
    chk("R11 hit", hit_o, 1);
    chk("R11 cfg", cfg_o, 8'h66);
    chk("R11 dist", dist_o, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule